// File: doc/BRIEF.md
# YCbCr to RGB Colour Converter

This block turns one 8-bit luma/chroma sample triple per clock into an 8-bit red, green and blue triple. The conversion matrix and the three input offsets are programmable. They come from three packed configuration words, so a display or video path can switch between studio-range and full-range standards, or use a custom matrix, without touching the datapath.

Each of the seven matrix coefficients is a 10-bit value with two integer bits and eight fraction bits. The integer part uses a non-two's-complement mapping, which lets a coefficient reach up to almost +3 while still covering small negative values. The datapath first adds offsets to the inputs. It then forms three multiply-accumulate sums, rounds them to the nearest integer and saturates each colour to 0..255.

The block is a three-stage pipeline with a valid flag alongside the data. The configuration words are captured into an internal copy only while the pipeline is empty. Software can therefore change them at any moment without corrupting samples already accepted.

Top module: `ycc_rgb_conv`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and all three colour outputs are 0. Until a configuration word is captured, every coefficient and every offset is zero.
- R2: A sample presented with `in_valid` high at clock edge n appears with `out_valid` high right after edge n+2. One result leaves for each accepted sample, in order, and back-to-back samples are accepted every cycle.
- R3: Each 10-bit coefficient field has an integer code in its upper 2 bits (code 0 gives 0, 1 gives +1, 2 gives +2, 3 gives -1) and a fraction in its lower 8 bits. Its value is the integer plus the fraction/256.
- R4: `cfg_word0` holds the Cr-to-blue coefficient's lower 8 bits in [31:24], the signed luma offset in [23:16], the signed Cb offset in [15:8] and the signed Cr offset in [7:0].
- R5: `cfg_word1` holds Cb-to-green in [31:22], Cr-to-green in [21:12] and the luma coefficient shared by all outputs in [11:2]. It also holds the upper 2 bits of Cr-to-blue in [1:0], which sit above the 8 bits held in `cfg_word0` [31:24].
- R6: `cfg_word2` (30 bits) holds Cb-to-red in [29:20], Cr-to-red in [19:10] and Cb-to-blue in [9:0].
- R7: The adjusted inputs are Y' = Y + luma offset, Cb' = Cb - 128 + Cb offset and Cr' = Cr - 128 + Cr offset. All offsets are signed 8-bit values.
- R8: The sums are: red = Ky·Y' + Kcr_r·Cr' + Kcb_r·Cb'; green = Ky·Y' + Kcb_g·Cb' + Kcr_g·Cr'; blue = Ky·Y' + Kcb_b·Cb' + Kcr_b·Cr'.
- R9: Each sum, in units of 1/256, is rounded by adding 128 and then dropping 8 bits with an arithmetic (floor) shift.
- R10: A rounded result below 0 gives 0, and one above 255 gives 255.
- R11: The configuration words are captured only at a clock edge where `in_valid` is low and no pipeline stage holds a sample. A word change while samples are in flight does not affect those samples.
- R12: When `out_valid` is low, the colour outputs keep the last result.
- R13: The triple (0x00f00000, 0xe73304a8, 0x00066204) gives the studio-range standard-definition matrix. The triple (0x00f00000, 0xf2b784a8, 0x00072a1c) gives the high-definition matrix. The triple (0x00000000, 0xea34a400, 0x000599c5) gives the full-range matrix. With the first triple, luma 235 at neutral chroma is white (255) and luma 16 is black (0). With the last triple, luma 200 at neutral chroma gives 200 on every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word0 | input | 32 | Offsets and low part of Cr-to-blue coefficient |
| cfg_word1 | input | 32 | Green and luma coefficients, top of Cr-to-blue |
| cfg_word2 | input | 30 | Red coefficients and Cb-to-blue |
| in_valid | input | 1 | Input sample valid |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output triple valid |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |

## Verification
Grey inputs at neutral chroma under the three standard word triples isolate the luma path, the luma offset and the presets. Words with a single non-zero coefficient field each land on one output, which exposes wrong field positions, the split Cr-to-blue field and the four integer codes. Luma values whose products fall on exact halves separate rounding from truncation, and extreme coefficients show that saturation acts at both ends. A word change in the middle of a back-to-back burst shows whether capture waits for an empty pipeline. A long random run with random gaps and random words checks every output against a bench model.

// File: rtl/ycc_rgb_pkg.sv
package ycc_rgb_pkg;

  localparam int CFG_W   = 32;
  localparam int FIELD_W = 10;
  localparam int FRAC_W  = 8;
  localparam int OFS_W   = 8;
  localparam int KW      = FIELD_W + 1;
  localparam int NCH     = 3;

  typedef struct packed {
    logic signed [KW-1:0]    k_y;
    logic signed [KW-1:0]    k_cr_r;
    logic signed [KW-1:0]    k_cb_r;
    logic signed [KW-1:0]    k_cb_g;
    logic signed [KW-1:0]    k_cr_g;
    logic signed [KW-1:0]    k_cb_b;
    logic signed [KW-1:0]    k_cr_b;
    logic signed [OFS_W-1:0] ofs_y;
    logic signed [OFS_W-1:0] ofs_cb;
    logic signed [OFS_W-1:0] ofs_cr;
  } ycc_cfg_t;

  // Integer code 2 is +2, code 3 is -1: one extra top bit set only for code 3
  function automatic logic signed [KW-1:0] coef_decode(input logic [FIELD_W-1:0] f);
    return {f[FIELD_W-1] & f[FIELD_W-2], f};
  endfunction

endpackage

// File: rtl/ycc_cfg_regs.sv
module ycc_cfg_regs
  import ycc_rgb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] w0,
  input  logic [CFG_W-1:0] w1,
  input  logic [CFG_W-3:0] w2,
  output ycc_cfg_t         cfg
);

  ycc_cfg_t nxt;

  always_comb begin
    nxt.ofs_cr = w0[7:0];
    nxt.ofs_cb = w0[15:8];
    nxt.ofs_y  = w0[23:16];
    nxt.k_cr_b = coef_decode({w1[1:0], w0[31:24]});
    nxt.k_y    = coef_decode(w1[11:2]);
    nxt.k_cr_g = coef_decode(w1[21:12]);
    nxt.k_cb_g = coef_decode(w1[31:22]);
    nxt.k_cb_b = coef_decode(w2[9:0]);
    nxt.k_cr_r = coef_decode(w2[19:10]);
    nxt.k_cb_r = coef_decode(w2[29:20]);
  end

  always_ff @(posedge clk) begin
    if (rst)       cfg <= '0;
    else if (load) cfg <= nxt;
  end

endmodule

// File: rtl/ycc_chan_mac.sv
module ycc_chan_mac #(
  parameter int ADJ_W = 10,
  parameter int KW    = 11,
  parameter int ACC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ADJ_W-1:0] y_a,
  input  logic signed [ADJ_W-1:0] cb_a,
  input  logic signed [ADJ_W-1:0] cr_a,
  input  logic signed [KW-1:0]    k_y,
  input  logic signed [KW-1:0]    k_cb,
  input  logic signed [KW-1:0]    k_cr,
  output logic signed [ACC_W-1:0] acc
);

  logic signed [ACC_W-1:0] p_y, p_cb, p_cr;

  always_comb begin
    p_y  = ACC_W'(k_y)  * ACC_W'(y_a);
    p_cb = ACC_W'(k_cb) * ACC_W'(cb_a);
    p_cr = ACC_W'(k_cr) * ACC_W'(cr_a);
  end

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= p_y + p_cb + p_cr;
  end

endmodule

// File: rtl/ycc_sat_round.sv
module ycc_sat_round #(
  parameter int ACC_W  = 23,
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc,
  output logic [PIX_W-1:0]        pix
);

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'(2 ** PIX_W - 1);

  logic signed [ACC_W-1:0] scaled;
  logic [PIX_W-1:0]        sat;

  always_comb begin
    scaled = (acc + HALF) >>> FRAC_W;
    if (scaled < 0)         sat = '0;
    else if (scaled > MAXV) sat = '1;
    else                    sat = scaled[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     pix <= '0;
    else if (en) pix <= sat;
  end

endmodule

// File: rtl/ycc_rgb_conv.sv
module ycc_rgb_conv
  import ycc_rgb_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      cfg_word0,
  input  logic [31:0]      cfg_word1,
  input  logic [29:0]      cfg_word2,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_y,
  input  logic [PIX_W-1:0] in_cb,
  input  logic [PIX_W-1:0] in_cr,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b
);

  localparam int ADJ_W = PIX_W + 2;
  localparam int ACC_W = KW + ADJ_W + 2;
  localparam logic signed [ADJ_W-1:0] MID = ADJ_W'(2 ** (PIX_W - 1));

  ycc_cfg_t cfg;
  logic     v1, v2, cfg_load;
  logic signed [ADJ_W-1:0] y_a, cb_a, cr_a;
  logic signed [KW-1:0]    k_cb [NCH];
  logic signed [KW-1:0]    k_cr [NCH];
  logic signed [ACC_W-1:0] acc  [NCH];
  logic [PIX_W-1:0]        pix  [NCH];

  // Capture words only with an empty pipeline and no arriving sample
  assign cfg_load = !in_valid && !v1 && !v2 && !out_valid;

  ycc_cfg_regs cfg_i (
    .clk(clk), .rst(rst), .load(cfg_load),
    .w0(cfg_word0), .w1(cfg_word1), .w2(cfg_word2), .cfg(cfg)
  );

  // Stage 1: offset adjustment
  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      y_a  <= '0;
      cb_a <= '0;
      cr_a <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        y_a  <= $signed(ADJ_W'(in_y)) + ADJ_W'(cfg.ofs_y);
        cb_a <= $signed(ADJ_W'(in_cb)) - MID + ADJ_W'(cfg.ofs_cb);
        cr_a <= $signed(ADJ_W'(in_cr)) - MID + ADJ_W'(cfg.ofs_cr);
      end
    end
  end

  // Channel order: 0 red, 1 green, 2 blue
  assign k_cb[0] = cfg.k_cb_r;
  assign k_cr[0] = cfg.k_cr_r;
  assign k_cb[1] = cfg.k_cb_g;
  assign k_cr[1] = cfg.k_cr_g;
  assign k_cb[2] = cfg.k_cb_b;
  assign k_cr[2] = cfg.k_cr_b;

  // Stages 2 and 3: valid tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v2        <= v1;
      out_valid <= v2;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    ycc_chan_mac #(.ADJ_W(ADJ_W), .KW(KW), .ACC_W(ACC_W)) mac_i (
      .clk(clk), .rst(rst), .en(v1),
      .y_a(y_a), .cb_a(cb_a), .cr_a(cr_a),
      .k_y(cfg.k_y), .k_cb(k_cb[c]), .k_cr(k_cr[c]),
      .acc(acc[c])
    );
    ycc_sat_round #(.ACC_W(ACC_W), .PIX_W(PIX_W), .FRAC_W(FRAC_W)) sat_i (
      .clk(clk), .rst(rst), .en(v2), .acc(acc[c]), .pix(pix[c])
    );
  end

  assign out_r = pix[0];
  assign out_g = pix[1];
  assign out_b = pix[2];

endmodule

// File: rtl/ycc_rgb_chk.sv
module ycc_rgb_chk
  import ycc_rgb_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             v1,
  input logic             v2,
  input logic             out_valid,
  input ycc_cfg_t         cfg,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b
);

  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_r == '0 && out_g == '0 && out_b == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3) |-> (out_valid == $past(in_valid, 3)));

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid || v1 || v2) |=> $stable(cfg));

  p_hold_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !v2 |=> $stable({out_r, out_g, out_b}));

endmodule

bind ycc_rgb_conv ycc_rgb_chk #(.PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .v1(v1), .v2(v2),
  .out_valid(out_valid), .cfg(cfg),
  .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/ycc_rgb_conv_tb_top.sv
module ycc_rgb_conv_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word0 = '0, cfg_word1 = '0;
  logic [29:0] cfg_word2 = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_y = '0, in_cb = '0, in_cr = '0;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] nx0 = '0, nx1 = '0, nx2 = '0;
  logic [31:0] act0 = '0, act1 = '0, act2 = '0;
  logic [2:0]  pipe = '0;
  logic [23:0] expq[$];
  string       tag = "R8";

  always #2 clk = ~clk;

  ycc_rgb_conv dut_i (
    .clk(clk), .rst(rst), .cfg_word0(cfg_word0), .cfg_word1(cfg_word1),
    .cfg_word2(cfg_word2), .in_valid(in_valid), .in_y(in_y), .in_cb(in_cb),
    .in_cr(in_cr), .out_valid(out_valid), .out_r(out_r), .out_g(out_g),
    .out_b(out_b)
  );

  function automatic int dec(input logic [9:0] f);
    int m;
    case (f[9:8])
      2'd0: m = 0;
      2'd1: m = 1;
      2'd2: m = 2;
      default: m = -1;
    endcase
    return m * 256 + int'(f[7:0]);
  endfunction

  function automatic int clamp8(input int s);
    int r;
    r = (s + 128) >>> 8;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  function automatic logic [23:0] model(input logic [31:0] a, b, c,
                                        input logic [7:0] y, cb, cr);
    int yo, cbo, cro, yp, cbp, crp, ky, r, g, bl;
    yo  = int'($signed(a[23:16]));
    cbo = int'($signed(a[15:8]));
    cro = int'($signed(a[7:0]));
    yp  = int'(y) + yo;
    cbp = int'(cb) - 128 + cbo;
    crp = int'(cr) - 128 + cro;
    ky  = dec(b[11:2]);
    r  = ky * yp + dec(c[19:10]) * crp + dec(c[29:20]) * cbp;
    g  = ky * yp + dec(b[31:22]) * cbp + dec(b[21:12]) * crp;
    bl = ky * yp + dec(c[9:0]) * cbp + dec({b[1:0], a[31:24]}) * crp;
    return {8'(clamp8(r)), 8'(clamp8(g)), 8'(clamp8(bl))};
  endfunction

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] y, cb, cr);
    logic [23:0] e;
    @(negedge clk);
    chk("R2 out_valid", int'(out_valid), int'(pipe[2]));
    if (pipe[2]) begin
      if (expq.size() == 0) chk("R2 extra result", 1, 0);
      else begin
        e = expq.pop_front();
        chk({tag, " red"},   int'(out_r), int'(e[23:16]));
        chk({tag, " green"}, int'(out_g), int'(e[15:8]));
        chk({tag, " blue"},  int'(out_b), int'(e[7:0]));
      end
    end
    cfg_word0 = nx0;
    cfg_word1 = nx1;
    cfg_word2 = nx2[29:0];
    in_valid = v; in_y = y; in_cb = cb; in_cr = cr;
    if (!v && pipe == 3'b000) begin
      act0 = nx0; act1 = nx1; act2 = {2'b00, nx2[29:0]};
    end
    if (v) expq.push_back(model(act0, act1, act2, y, cb, cr));
    pipe = {pipe[1:0], v};
  endtask

  task automatic set_cfg(input logic [31:0] a, b, c);
    nx0 = a; nx1 = b; nx2 = c;
    step(0, 0, 0, 0);
  endtask

  task automatic run1(input logic [7:0] y, cb, cr);
    step(1, y, cb, cr);
    repeat (4) step(0, 0, 0, 0);
  endtask

  task automatic chk3(input string t, input int r, g, b);
    chk({t, " red"}, int'(out_r), r);
    chk({t, " green"}, int'(out_g), g);
    chk({t, " blue"}, int'(out_b), b);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk3("R1 reset outputs", 0, 0, 0);

    // R1: zero config until capture: first sample with zero words gives zero
    tag = "R1";
    run1(8'd200, 8'd10, 8'd250);
    chk3("R1 zero config", 0, 0, 0);

    // R13 presets
    tag = "R13";
    set_cfg(32'h00f00000, 32'he73304a8, 32'h00066204);
    run1(8'd235, 8'd128, 8'd128);
    chk3("R13 white", 255, 255, 255);
    run1(8'd16, 8'd128, 8'd128);
    chk3("R13 black", 0, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 8'($urandom), 8'($urandom), 8'($urandom));
    set_cfg(32'h00f00000, 32'hf2b784a8, 32'h00072a1c);
    repeat (3) step(0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 8'($urandom), 8'($urandom), 8'($urandom));
    repeat (4) step(0, 0, 0, 0);
    set_cfg(32'h00000000, 32'hea34a400, 32'h000599c5);
    run1(8'd200, 8'd128, 8'd128);
    chk3("R13 full-range grey", 200, 200, 200);

    // R3 integer codes 3 (-1) and 2 (+2) on Cr-to-red, R6 position
    tag = "R3";
    set_cfg(32'h0, 32'h0, 32'h000E0000);
    run1(8'd0, 8'd128, 8'd0);
    chk3("R3 code3 crr R6", 64, 0, 0);
    set_cfg(32'h0, 32'h0, 32'h00080000);
    run1(8'd0, 8'd128, 8'd160);
    chk3("R3 code2 crr", 64, 0, 0);

    // R5 and R4: Cr-to-blue split across words (1.25)
    tag = "R5";
    set_cfg(32'h40000000, 32'h00000001, 32'h0);
    run1(8'd0, 8'd128, 8'd228);
    chk3("R5 R4 split crb", 0, 0, 125);

    // R7 offsets: luma -16, Cb +10, Ky 1.0, Cb-to-red 1.0
    tag = "R7";
    set_cfg(32'h00F00A00, 32'h00000400, 32'h10000000);
    run1(8'd100, 8'd128, 8'd128);
    chk3("R7 offsets", 94, 84, 84);

    // R9 rounding with Ky = 0.5
    tag = "R9";
    set_cfg(32'h0, 32'h00000200, 32'h0);
    run1(8'd3, 8'd128, 8'd128);
    chk3("R9 1.5 rounds up", 2, 2, 2);
    run1(8'd5, 8'd128, 8'd128);
    chk3("R9 2.5 rounds up", 3, 3, 3);

    // R10 saturation both ends
    tag = "R10";
    set_cfg(32'h0, 32'h00000BFC, 32'h0);
    run1(8'd255, 8'd128, 8'd128);
    chk3("R10 high clamp", 255, 255, 255);
    set_cfg(32'h0, 32'h00000C00, 32'h0);
    run1(8'd50, 8'd128, 8'd128);
    chk3("R10 low clamp", 0, 0, 0);

    // R11 config change during a burst, R12 hold
    tag = "R11";
    set_cfg(32'h0, 32'h00000400, 32'h0);
    step(1, 8'd100, 8'd128, 8'd128);
    nx1 = 32'h00000800;
    repeat (3) step(1, 8'd100, 8'd128, 8'd128);
    repeat (6) step(0, 0, 0, 0);
    chk3("R11 burst kept old config R12 hold", 100, 100, 100);
    run1(8'd100, 8'd128, 8'd128);
    chk3("R11 new config after idle", 200, 200, 200);

    // Random run with gaps and word changes
    tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) begin
        nx0 = $urandom; nx1 = $urandom; nx2 = $urandom;
      end
      step(($urandom % 4) != 0, 8'($urandom), 8'($urandom), 8'($urandom));
    end
    repeat (5) step(0, 0, 0, 0);
    chk("R2 all results delivered", expq.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule